// File: doc/BRIEF.md
# Multiple-Bus Request Arbiter

This block decides, once per bus cycle, which processors may use one of a small set of shared buses to reach a set of memory modules. Each processor presents a valid flag and the index of the memory it wants. Arbitration has two stages. In the first, every memory picks at most one of the processors that target it. In the second, the memories picked in the first stage compete for the buses, which are handed out in rotating order. Each bus cycle is one clock. The result is registered and appears one clock after the requests are sampled: a grant flag and a bus number for each processor, and a busy flag for each bus.

A processor that is not granted keeps its request and target unchanged and tries again in the next cycle. A processor that sees its grant either withdraws its request or presents its next one before the following clock edge. A parameter can split the buses and the memories into equal groups. A memory then uses only the buses of its own group, and each group is arbitrated on its own.

Top module: `multibus_arbiter`

## Requirements
- R1: While reset is low at a clock edge, all grant flags, bus numbers and bus-busy flags read zero after that edge, even if requests are present.
- R2: A processor's grant flag is high in the clock after an edge at which that processor presented a valid request, and only then. The grant lasts one clock.
- R3: In any one cycle at most one processor is granted per memory.
- R4: Each memory keeps a rotating processor pointer that starts at processor 0. The memory's winner is the first requesting processor at or above the pointer, wrapping from N-1 to 0. The pointer moves to winner+1 (mod N) only when that winner also receives a bus. Otherwise it stays where it is.
- R5: In each group, the number of buses granted per cycle equals the smaller of the group's bus count and the number of that group's memories that have a winner. A group never blocks a winning memory while it still has a free bus.
- R6: Each group keeps a rotating memory pointer over its local memories (0 up to M/g-1) that starts at 0. Memories with a winner are served in ascending local order from the pointer, wrapping. The k-th memory served (k from 0) gets bus number group*(B/g)+k. The pointer then moves to one past the last memory served, and stays put if none was served.
- R7: A request that is held stable while it is blocked is granted within N cycles when every processor competes for a single memory.
- R8: The group count g must divide both B and M, otherwise elaboration fails. Memory j belongs to group j/(M/g). The buses of group h are h*(B/g) up to h*(B/g)+B/g-1. Every group has its own pointers and is never affected by requests to another group.
- R9: Bus-busy bit k is high exactly when bus k is granted. The number of busy buses equals the number of granted processors. A processor without a grant reads bus number 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one edge per bus cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | N_PROC | Request valid, one bit per processor |
| req_mem | input | N_PROC*MEM_W | Target memory index per processor, processor i at bits i*MEM_W upward |
| gnt | output | N_PROC | Registered grant flag per processor |
| gnt_bus | output | N_PROC*BUS_W | Registered granted bus number per processor |
| bus_busy | output | N_BUS | Registered in-use flag per bus |

## Verification
Two instances run side by side, one with a single group and one with two groups. Each has its own processors, and each processor holds a blocked request until it is granted. A lone request checks the index mapping and separates the grouped bus numbering from the ungrouped one. All processors aimed at one memory exercise only the stage-one rotation and its N-cycle bound. Every processor aimed at a different memory leaves stage one idle and shows bus shortage and the stage-two rotation. Requests confined to one group show the grouped instance serialising them while the other instance serves them at once. A long pseudo-random phase with retries compares every output of every cycle against a reference model built from the requirements.

// File: rtl/mba_pkg.sv
// Package: shared helpers for the multiple-bus arbiter.
// Assumes: callers pass counts of at least 1.
package mba_pkg;

    // Width of an index that can address n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mba_mem_arb.sv
// Module: stage-one arbiter for one memory module.
// Picks at most one of the processors that target memory MEM_ID, in rotating
// order from its own pointer. Assumes the pointer moves only when the bus
// stage confirms the winner (served input).
module mba_mem_arb
    import mba_pkg::*;
#(
    parameter int N_PROC = 4,
    parameter int MEM_W  = 2,
    parameter int MEM_ID = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PROC-1:0]         req_vld,
    input  logic [N_PROC*MEM_W-1:0]   req_mem,
    input  logic                      served,
    output logic                      win_vld,
    output logic [idx_w(N_PROC)-1:0]  win_idx
);
    localparam int PW = idx_w(N_PROC);

    logic [N_PROC-1:0] cand;
    logic [PW-1:0]     ptr;
    logic [PW-1:0]     ptr_nxt;

    // Mark processors whose valid request targets this memory.
    always_comb begin
        for (int i = 0; i < N_PROC; i++) begin
            cand[i] = req_vld[i] && (req_mem[i*MEM_W +: MEM_W] == MEM_W'(MEM_ID));
        end
    end

    // Scan from the pointer upward; the nearest candidate wins.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int o = N_PROC - 1; o >= 0; o--) begin
            int k;
            k = (int'(ptr) + o) % N_PROC;
            if (cand[k]) begin
                win_vld = 1'b1;
                win_idx = PW'(k);
            end
        end
    end

    // Next pointer: one past the winner, wrapping.
    always_comb begin
        ptr_nxt = (int'(win_idx) == N_PROC - 1) ? '0 : win_idx + PW'(1);
    end

    // Advance the pointer only for a winner that also got a bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (win_vld && served) begin
            ptr <= ptr_nxt;
        end
    end

    AST_WIN_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> cand[win_idx]);                                    // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld && !served) |=> $stable(ptr));                         // R4
    AST_NO_IDLE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |-> !win_vld);                                     // R4

endmodule

// File: rtl/mba_bus_alloc.sv
// Module: stage-two bus allocator for one group.
// Hands up to BPG local buses to the group's memories that have a stage-one
// winner, in rotating order from its own pointer. Assumes MPG, BPG >= 1.
module mba_bus_alloc
    import mba_pkg::*;
#(
    parameter int MPG = 4,
    parameter int BPG = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [MPG-1:0]              dem,
    output logic [MPG-1:0]              served,
    output logic [MPG*idx_w(BPG)-1:0]   bus_sel,
    output logic [BPG-1:0]              bus_used
);
    localparam int BLW = idx_w(BPG);
    localparam int RW  = idx_w(MPG);

    logic [RW-1:0] rptr;
    logic [RW-1:0] rptr_nxt;
    logic          any_srv;
    int            n_srv;

    // Walk memories from the pointer, give each demand the next free bus.
    always_comb begin
        int last;
        served  = '0;
        bus_sel = '0;
        n_srv   = 0;
        last    = 0;
        any_srv = 1'b0;
        for (int o = 0; o < MPG; o++) begin
            int lj;
            lj = (int'(rptr) + o) % MPG;
            for (int m = 0; m < MPG; m++) begin
                if (m == lj && dem[m] && n_srv < BPG) begin
                    served[m]               = 1'b1;
                    bus_sel[m*BLW +: BLW]   = BLW'(n_srv);
                    n_srv                   = n_srv + 1;
                    last                    = lj;
                    any_srv                 = 1'b1;
                end
            end
        end
        rptr_nxt = RW'((last + 1) % MPG);
    end

    // Buses below the served count are in use.
    always_comb begin
        for (int k = 0; k < BPG; k++) begin
            bus_used[k] = (k < n_srv);
        end
    end

    // Move the pointer past the last memory served this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
        end else if (any_srv) begin
            rptr <= rptr_nxt;
        end
    end

    AST_NO_SHORTAGE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dem) <= BPG) |-> (served == dem));                  // R5
    AST_SERVED_HAS_DEM: assert property (@(posedge clk) disable iff (!rst_n)
        (served & ~dem) == '0);                                         // R5
    AST_USED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(served) == $countones(bus_used));                    // R9

endmodule

// File: rtl/multibus_arbiter.sv
// Module: two-stage multiple-bus arbiter (top).
// N_PROC processors reach N_MEM memories over N_BUS buses. Stage one has one
// arbiter per memory, stage two one bus allocator per group. Outputs are
// registered: one clock after the requests are sampled. Assumes processors
// hold blocked requests stable and N_GRP divides N_BUS and N_MEM.
module multibus_arbiter
    import mba_pkg::*;
#(
    parameter int N_PROC = 4,
    parameter int N_MEM  = 4,
    parameter int N_BUS  = 2,
    parameter int N_GRP  = 1,
    localparam int MEM_W = idx_w(N_MEM),
    localparam int BUS_W = idx_w(N_BUS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PROC-1:0]         req_vld,
    input  logic [N_PROC*MEM_W-1:0]   req_mem,
    output logic [N_PROC-1:0]         gnt,
    output logic [N_PROC*BUS_W-1:0]   gnt_bus,
    output logic [N_BUS-1:0]          bus_busy
);
    localparam int PW  = idx_w(N_PROC);
    localparam int MPG = N_MEM / N_GRP;
    localparam int BPG = N_BUS / N_GRP;
    localparam int BLW = idx_w(BPG);

    logic [N_MEM-1:0]       win_vld;
    logic [PW-1:0]          win_idx [N_MEM];
    logic [N_MEM-1:0]       mem_srv;
    logic [BUS_W-1:0]       mem_bus [N_MEM];
    logic [N_BUS-1:0]       busy_nxt;
    logic [N_PROC-1:0]      gnt_nxt;
    logic [N_PROC*BUS_W-1:0] bus_nxt;
    logic [N_MEM-1:0]       mem_req;

    initial begin
        AST_GRP_DIV: assert ((N_BUS % N_GRP == 0) && (N_MEM % N_GRP == 0))
            else $error("group count must divide bus and memory counts"); // R8
    end

    // Stage one: one arbiter per memory module.
    for (genvar j = 0; j < N_MEM; j++) begin : g_mem
        mba_mem_arb #(
            .N_PROC (N_PROC),
            .MEM_W  (MEM_W),
            .MEM_ID (j)
        ) i_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_vld (req_vld),
            .req_mem (req_mem),
            .served  (mem_srv[j]),
            .win_vld (win_vld[j]),
            .win_idx (win_idx[j])
        );
    end

    // Stage two: one allocator per group, mapped onto global bus numbers.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [MPG*BLW-1:0] sel_loc;
        mba_bus_alloc #(
            .MPG (MPG),
            .BPG (BPG)
        ) i_alloc (
            .clk      (clk),
            .rst_n    (rst_n),
            .dem      (win_vld[g*MPG +: MPG]),
            .served   (mem_srv[g*MPG +: MPG]),
            .bus_sel  (sel_loc),
            .bus_used (busy_nxt[g*BPG +: BPG])
        );
        for (genvar lj = 0; lj < MPG; lj++) begin : g_map
            assign mem_bus[g*MPG + lj] = BUS_W'(g * BPG) + BUS_W'(sel_loc[lj*BLW +: BLW]);
        end
    end

    // Route each memory's result back to the processor that won it.
    always_comb begin
        gnt_nxt = '0;
        bus_nxt = '0;
        for (int i = 0; i < N_PROC; i++) begin
            for (int j = 0; j < N_MEM; j++) begin
                if (req_vld[i] && req_mem[i*MEM_W +: MEM_W] == MEM_W'(j) &&
                    win_vld[j] && win_idx[j] == PW'(i) && mem_srv[j]) begin
                    gnt_nxt[i]                   = 1'b1;
                    bus_nxt[i*BUS_W +: BUS_W]    = mem_bus[j];
                end
            end
        end
    end

    // Register the cycle's outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt      <= '0;
            gnt_bus  <= '0;
            bus_busy <= '0;
        end else begin
            gnt      <= gnt_nxt;
            gnt_bus  <= bus_nxt;
            bus_busy <= busy_nxt;
        end
    end

    // Memories that have at least one valid request (checker input).
    always_comb begin
        mem_req = '0;
        for (int i = 0; i < N_PROC; i++) begin
            for (int j = 0; j < N_MEM; j++) begin
                if (req_vld[i] && req_mem[i*MEM_W +: MEM_W] == MEM_W'(j)) begin
                    mem_req[j] = 1'b1;
                end
            end
        end
    end

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gnt & ~$past(req_vld)) == '0));                      // R2
    AST_ONE_PER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(gnt) <= $countones($past(mem_req))));      // R3
    AST_BUS_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(bus_busy) <= $countones($past(mem_req)))); // R5
    AST_GNT_BUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) == $countones(bus_busy));                       // R9

    for (genvar i = 0; i < N_PROC; i++) begin : g_chk
        AST_GRP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (!gnt[i] || (int'(gnt_bus[i*BUS_W +: BUS_W]) / BPG ==
                                  int'($past(req_mem[i*MEM_W +: MEM_W])) / MPG))); // R8
        AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !gnt[i] |-> (gnt_bus[i*BUS_W +: BUS_W] == '0));            // R9
    end

endmodule

// File: tb/test_multibus_arbiter.sv
// Bench: two arbiters (ungrouped and two groups) with separate processors.
// A driver task applies requests, runs a reference model and queues the
// expected outputs; a monitor pops and compares them each cycle.
module test_multibus_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NM = 4;
    localparam int NB = 2;

    typedef struct packed {
        logic [3:0] gnt_a;
        logic [3:0] bus_a;
        logic [1:0] busy_a;
        logic [3:0] gnt_b;
        logic [3:0] bus_b;
        logic [1:0] busy_b;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] vld_a = '0, vld_b = '0;
    logic [7:0] mem_a = '0, mem_b = '0;
    logic [3:0] gnt_a, gnt_b, bus_a, bus_b;
    logic [1:0] busy_a, busy_b;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    bit    pv [2][NP];
    int    pm [2][NP];
    int    p1 [2][NM];
    int    p2 [2][2];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    multibus_arbiter #(.N_PROC(NP), .N_MEM(NM), .N_BUS(NB), .N_GRP(1)) i_multibus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_vld(vld_a), .req_mem(mem_a),
        .gnt(gnt_a), .gnt_bus(bus_a), .bus_busy(busy_a));

    multibus_arbiter #(.N_PROC(NP), .N_MEM(NM), .N_BUS(NB), .N_GRP(2)) i_multibus_arbiter_grp (
        .clk(clk), .rst_n(rst_n), .req_vld(vld_b), .req_mem(mem_b),
        .gnt(gnt_b), .gnt_bus(bus_b), .bus_busy(busy_b));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    // Reference model of one cycle for instance d with grp groups.
    task automatic model(input int d, input int grp, output logic [3:0] g,
                         output logic [3:0] bs, output logic [1:0] busy);
        int win [NM];
        int mpg, bpg;
        mpg = NM / grp;
        bpg = NB / grp;
        g = '0; bs = '0; busy = '0;
        for (int j = 0; j < NM; j++) begin
            win[j] = -1;
            for (int o = 0; o < NP; o++) begin
                int i;
                i = (p1[d][j] + o) % NP;
                if (win[j] < 0 && pv[d][i] && pm[d][i] == j) win[j] = i;
            end
        end
        for (int gi = 0; gi < grp; gi++) begin
            int cnt, last;
            cnt = 0; last = -1;
            for (int o = 0; o < mpg; o++) begin
                int lj, j;
                lj = (p2[d][gi] + o) % mpg;
                j  = gi * mpg + lj;
                if (win[j] >= 0 && cnt < bpg) begin
                    g[win[j]]              = 1'b1;
                    bs[win[j]]             = 1'((gi * bpg + cnt) % 2);
                    busy[gi * bpg + cnt]   = 1'b1;
                    p1[d][j]               = (win[j] + 1) % NP;
                    cnt++;
                    last = lj;
                end
            end
            if (last >= 0) p2[d][gi] = (last + 1) % mpg;
        end
    endtask

    // Apply one cycle of requests, queue expected outputs, retire grants.
    task automatic step(input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        for (int i = 0; i < NP; i++) begin
            vld_a[i] = pv[0][i];
            vld_b[i] = pv[1][i];
            mem_a[i*2 +: 2] = 2'(pm[0][i]);
            mem_b[i*2 +: 2] = 2'(pm[1][i]);
        end
        model(0, 1, e.gnt_a, e.bus_a, e.busy_a);
        model(1, 2, e.gnt_b, e.bus_b, e.busy_b);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 0; i < NP; i++) begin
            if (e.gnt_a[i]) pv[0][i] = 1'b0;
            if (e.gnt_b[i]) pv[1][i] = 1'b0;
        end
    endtask

    function automatic bit idle(input int d);
        for (int i = 0; i < NP; i++) if (pv[d][i]) return 1'b0;
        return 1'b1;
    endfunction

    // Monitor: compare the design's outputs with the queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(gnt_a  == e.gnt_a,  {t, " grant (one group)"}, gnt_a, e.gnt_a);
            check(bus_a  == e.bus_a,  {t, " R9 bus number (one group)"}, bus_a, e.bus_a);
            check(busy_a == e.busy_a, {t, " R9 busy (one group)"}, busy_a, e.busy_a);
            check(gnt_b  == e.gnt_b,  {t, " R8 grant (two groups)"}, gnt_b, e.gnt_b);
            check(bus_b  == e.bus_b,  {t, " R8 bus number (two groups)"}, bus_b, e.bus_b);
            check(busy_b == e.busy_b, {t, " R8 busy (two groups)"}, busy_b, e.busy_b);
        end
    end

    // Run until both instances have drained; report cycles each needed.
    task automatic drain(input string tag, output int na, output int nb);
        na = 0; nb = 0;
        while (!idle(0) || !idle(1)) begin
            if (!idle(0)) na++;
            if (!idle(1)) nb++;
            step(tag);
        end
    endtask

    initial begin
        int na, nb;
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < NP; i++) begin pv[d][i] = 1'b0; pm[d][i] = 0; end
            for (int j = 0; j < NM; j++) p1[d][j] = 0;
            p2[d][0] = 0; p2[d][1] = 0;
        end
        // R1: requests present while reset is held.
        vld_a = '1; vld_b = '1;
        repeat (3) @(negedge clk);
        check(gnt_a == 0 && busy_a == 0 && bus_a == 0, "R1 reset (one group)", {gnt_a, bus_a, busy_a}, 0);
        check(gnt_b == 0 && busy_b == 0 && bus_b == 0, "R1 reset (two groups)", {gnt_b, bus_b, busy_b}, 0);
        #1;
        vld_a = '0; vld_b = '0;
        rst_n = 1'b1;

        // R6: lone request, processor 0 to memory 2.
        for (int d = 0; d < 2; d++) begin pv[d][0] = 1'b1; pm[d][0] = 2; end
        step("R6 lone request");
        step("R2 grant lasts one cycle");

        // R4, R7: every processor to memory 1, held until granted.
        for (int d = 0; d < 2; d++) for (int i = 0; i < NP; i++) begin pv[d][i] = 1'b1; pm[d][i] = 1; end
        drain("R4 single-memory conflict", na, nb);
        check(na == NP, "R7 held requests served (one group)", na, NP);
        check(nb == NP, "R7 held requests served (two groups)", nb, NP);

        // R5: each processor to its own memory, buses run short.
        for (int d = 0; d < 2; d++) for (int i = 0; i < NP; i++) begin pv[d][i] = 1'b1; pm[d][i] = i; end
        drain("R5 bus shortage", na, nb);
        check(na == 2, "R5 cycles for four memories on two buses", na, 2);
        check(nb == 2, "R5 cycles for two groups of one bus", nb, 2);

        // R8: both requests in group 0 only.
        for (int d = 0; d < 2; d++) begin
            pv[d][2] = 1'b1; pm[d][2] = 0;
            pv[d][3] = 1'b1; pm[d][3] = 1;
        end
        drain("R8 one group loaded", na, nb);
        check(na == 1, "R8 ungrouped serves both at once", na, 1);
        check(nb == 2, "R8 grouped serialises one group", nb, 2);

        // R4: steady contention for memory 0, rerequest right after grant.
        for (int c = 0; c < 12; c++) begin
            for (int d = 0; d < 2; d++) for (int i = 0; i < NP; i++) begin pv[d][i] = 1'b1; pm[d][i] = 0; end
            step("R4 rotation");
        end
        drain("R4 rotation drain", na, nb);

        // R2, R3, R6, R9: random traffic with retries.
        for (int c = 0; c < 300; c++) begin
            for (int d = 0; d < 2; d++) begin
                for (int i = 0; i < NP; i++) begin
                    lfsr = lfsr_next(lfsr);
                    if (!pv[d][i] && lfsr[0]) begin
                        pv[d][i] = 1'b1;
                        pm[d][i] = int'(lfsr[5:4]);
                    end
                end
            end
            step("R3 R6 random traffic");
        end
        drain("R2 random drain", na, nb);
        step("R9 idle after drain");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule